// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block sits behind an external dual-modulus prescaler in a frequency synthesizer loop. It counts the prescaler's output pulses and drives the prescaler's modulus-control line. Together they divide the oscillator by P×N+A, where P is the prescaler's base modulus. The prescaler divides by P+1 while modulus control is high and by P while it is low. At the start of every division cycle, two counters are loaded: a main count N and a swallow count A. Modulus control stays high for the first A prescaler pulses and low for the remaining N−A pulses. When the Nth pulse arrives, the block emits one comparison pulse and starts the next cycle.

Software-facing values (N, A and the base-modulus select bit) are written into a shadow stage. They take effect only when the next cycle starts, so a cycle is never split between two settings. Values that would give a malformed cycle are clamped to the nearest legal setting, and an error flag is raised.

Each prescaler output pulse is presented to the block as a one-clock strobe, synchronous to the block clock.

Top module: `swl_pulse_swallow`

## Requirements
- R1: While reset is asserted, and until the first prescaler strobe after it, `cmp_o`, `mod_ctl_o`, `mod_sel_o` and `cfg_err_o` are all 0. The active setting is N=3, A=0, select 0.
- R2: In each division cycle, `mod_ctl_o` is 1 from the reload until A prescaler strobes have been counted, then 0 for the rest of the cycle. With A=0 it never rises in that cycle.
- R3: `cmp_o` is high for exactly one clock, in the clock after the strobe that completes the Nth count of the cycle. The counters reload on that same clock edge.
- R4: With a prescaler that divides by P+1 while `mod_ctl_o` is 1 and by P otherwise, consecutive `cmp_o` pulses are exactly P×N+A clocks apart. P is 32 when `mod_sel_o` is 0 and 64 when it is 1.
- R5: A write (`cfg_wr_i`=1) stores N, A and select in a shadow stage. These become active at the next reload. A write made in the very clock of a reload is not used by that reload; it applies at the following one. A later write before a reload replaces an earlier one.
- R6: `mod_sel_o` changes only on a reload, that is, in the clock where `cmp_o` is 1.
- R7: A written N below 3 is used as N=3, and `cfg_err_o` becomes 1 in the clock after the write.
- R8: A written A that is not less than the written N (after N is clamped) is used as N−1. `cfg_err_o` is 1 after a write whose raw N<3 or raw A≥N, is 0 after a legal write, and changes only in the clock after a write.
- R9: In a clock with no prescaler strobe, the counters hold, and `mod_ctl_o` is unchanged in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_pulse_i | input | 1 | One-clock strobe per prescaler output pulse |
| cfg_wr_i | input | 1 | Write strobe for the shadow setting |
| cfg_n_i | input | 11 | Main count N to write |
| cfg_a_i | input | 7 | Swallow count A to write |
| cfg_sel_i | input | 1 | Base-modulus select to write |
| mod_ctl_o | output | 1 | Modulus control: 1 selects divide by P+1 |
| mod_sel_o | output | 1 | Active base-modulus select |
| cmp_o | output | 1 | One-clock pulse per completed division cycle |
| cfg_err_o | output | 1 | Last written setting was illegal and was clamped |

## Verification
Two events can land in the same clock: a configuration write, and the reload triggered by the final prescaler strobe of a cycle. The bench provokes this by holding a pending write until the clock in which its own prescaler model issues a terminal strobe, then asserting `cfg_wr_i` in that clock. A behavioural model decides the outcome: the reload must use the previous setting, and the written value must appear only one cycle later. This is judged both by per-clock comparison of `mod_ctl_o`, `mod_sel_o` and `cmp_o`, and by the measured spacing of `cmp_o` pulses.

// File: rtl/swl_pkg.sv
package swl_pkg;

  localparam int unsigned SWL_N_W = 11;
  localparam int unsigned SWL_A_W = 7;

  typedef struct packed {
    logic [SWL_N_W-1:0] n;
    logic [SWL_A_W-1:0] a;
    logic               sel;
  } swl_cfg_t;

  // Legal form of a written setting: N raised to the floor, A kept below N.
  function automatic swl_cfg_t swl_clamp(input logic [SWL_N_W-1:0] n,
                                         input logic [SWL_A_W-1:0] a,
                                         input logic               sel,
                                         input logic [SWL_N_W-1:0] n_floor);
    swl_cfg_t c;
    logic [SWL_N_W-1:0] a_ext;
    c.sel = sel;
    c.n   = (n < n_floor) ? n_floor : n;
    a_ext = {{(SWL_N_W-SWL_A_W){1'b0}}, a};
    c.a   = (a_ext >= c.n) ? SWL_A_W'(c.n - SWL_N_W'(1)) : a;
    return c;
  endfunction

  function automatic logic swl_is_bad(input logic [SWL_N_W-1:0] n,
                                      input logic [SWL_A_W-1:0] a,
                                      input logic [SWL_N_W-1:0] n_floor);
    logic [SWL_N_W-1:0] a_ext;
    a_ext = {{(SWL_N_W-SWL_A_W){1'b0}}, a};
    return (n < n_floor) || (a_ext >= n);
  endfunction

endpackage

// File: rtl/swl_cfg_buf.sv
module swl_cfg_buf
  import swl_pkg::*;
#(
  parameter int unsigned N_MIN = 3,
  parameter int unsigned N_RST = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_i,
  input  swl_cfg_t wr_cfg_i,
  input  logic     reload_i,
  output swl_cfg_t next_cfg_o,
  output swl_cfg_t act_cfg_o,
  output logic     err_o
);

  localparam logic [SWL_N_W-1:0] N_FLOOR = SWL_N_W'(N_MIN);
  localparam swl_cfg_t CFG_RST = '{n: SWL_N_W'(N_RST), a: '0, sel: 1'b0};

  swl_cfg_t sh_q, sh_d, act_q, act_d;
  logic     pend_q, pend_d;
  logic     err_q, err_d;
  logic     sh_en, act_en, pend_en, err_en;

  always_comb begin
    sh_d    = sh_q;
    act_d   = act_q;
    pend_d  = pend_q;
    err_d   = err_q;
    sh_en   = 1'b0;
    act_en  = 1'b0;
    pend_en = 1'b0;
    err_en  = 1'b0;
    if (reload_i && pend_q) begin
      act_d   = sh_q;
      act_en  = 1'b1;
      pend_d  = 1'b0;
      pend_en = 1'b1;
    end
    if (wr_i) begin
      sh_d    = swl_clamp(wr_cfg_i.n, wr_cfg_i.a, wr_cfg_i.sel, N_FLOOR);
      sh_en   = 1'b1;
      pend_d  = 1'b1;
      pend_en = 1'b1;
      err_d   = swl_is_bad(wr_cfg_i.n, wr_cfg_i.a, N_FLOOR);
      err_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= CFG_RST;
      act_q  <= CFG_RST;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (sh_en)   sh_q   <= sh_d;
      if (act_en)  act_q  <= act_d;
      if (pend_en) pend_q <= pend_d;
      if (err_en)  err_q  <= err_d;
    end
  end

  assign next_cfg_o = pend_q ? sh_q : act_q;
  assign act_cfg_o  = act_q;
  assign err_o      = err_q;

endmodule

// File: rtl/swl_count_core.sv
module swl_count_core
  import swl_pkg::*;
#(
  parameter int unsigned N_RST = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pulse_i,
  input  swl_cfg_t load_cfg_i,
  output logic     tc_o,
  output logic     mod_ctl_o,
  output logic     cmp_o
);

  logic [SWL_N_W-1:0] n_q, n_d;
  logic [SWL_A_W-1:0] a_q, a_d;
  logic               cmp_q, cmp_d;
  logic               tc;

  assign tc = pulse_i && (n_q == SWL_N_W'(1));

  always_comb begin
    n_d   = n_q;
    a_d   = a_q;
    cmp_d = tc;
    if (tc) begin
      n_d = load_cfg_i.n;
      a_d = load_cfg_i.a;
    end else if (pulse_i) begin
      n_d = n_q - SWL_N_W'(1);
      if (a_q != '0) a_d = a_q - SWL_A_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= SWL_N_W'(N_RST);
      a_q   <= '0;
      cmp_q <= 1'b0;
    end else begin
      if (pulse_i) begin
        n_q <= n_d;
        a_q <= a_d;
      end
      cmp_q <= cmp_d;
    end
  end

  assign tc_o      = tc;
  assign mod_ctl_o = (a_q != '0);
  assign cmp_o     = cmp_q;

endmodule

// File: rtl/swl_pulse_swallow.sv
module swl_pulse_swallow
  import swl_pkg::*;
#(
  parameter int unsigned N_MIN = 3,
  parameter int unsigned N_RST = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pre_pulse_i,
  input  logic               cfg_wr_i,
  input  logic [SWL_N_W-1:0] cfg_n_i,
  input  logic [SWL_A_W-1:0] cfg_a_i,
  input  logic               cfg_sel_i,
  output logic               mod_ctl_o,
  output logic               mod_sel_o,
  output logic               cmp_o,
  output logic               cfg_err_o
);

  swl_cfg_t wr_cfg, next_cfg, act_cfg;
  logic     reload;

  assign wr_cfg = '{n: cfg_n_i, a: cfg_a_i, sel: cfg_sel_i};

  swl_cfg_buf #(.N_MIN(N_MIN), .N_RST(N_RST)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (cfg_wr_i),
    .wr_cfg_i  (wr_cfg),
    .reload_i  (reload),
    .next_cfg_o(next_cfg),
    .act_cfg_o (act_cfg),
    .err_o     (cfg_err_o)
  );

  swl_count_core #(.N_RST(N_RST)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_i   (pre_pulse_i),
    .load_cfg_i(next_cfg),
    .tc_o      (reload),
    .mod_ctl_o (mod_ctl_o),
    .cmp_o     (cmp_o)
  );

  assign mod_sel_o = act_cfg.sel;

endmodule

// File: rtl/swl_chk.sv
module swl_chk (
  input logic clk,
  input logic rst_n,
  input logic pre_pulse_i,
  input logic cfg_wr_i,
  input logic mod_ctl_o,
  input logic mod_sel_o,
  input logic cmp_o,
  input logic cfg_err_o
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3: a comparison pulse never lasts two clocks
  p_cmp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_o |=> !cmp_o);

  // R2: modulus control only rises at a reload
  p_mod_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(mod_ctl_o)) |-> cmp_o);

  // R6: active select only moves on a reload
  p_sel_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (mod_sel_o != $past(mod_sel_o))) |-> cmp_o);

  // R8: error flag only moves after a write
  p_err_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (cfg_err_o != $past(cfg_err_o))) |-> $past(cfg_wr_i));

  // R9: no strobe, no change in modulus control
  p_mod_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_pulse_i |=> $stable(mod_ctl_o));

endmodule

bind swl_pulse_swallow swl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pre_pulse_i(pre_pulse_i),
  .cfg_wr_i   (cfg_wr_i),
  .mod_ctl_o  (mod_ctl_o),
  .mod_sel_o  (mod_sel_o),
  .cmp_o      (cmp_o),
  .cfg_err_o  (cfg_err_o)
);

// File: tb/tb_swl_pulse_swallow.sv
`timescale 1ns/1ps
module tb_swl_pulse_swallow;

  localparam int P_LO = 32;
  localparam int P_HI = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pre_pulse_i;
  logic        cfg_wr_i;
  logic [10:0] cfg_n_i;
  logic [6:0]  cfg_a_i;
  logic        cfg_sel_i;
  logic        mod_ctl_o, mod_sel_o, cmp_o, cfg_err_o;

  always #2 clk = ~clk;

  swl_pulse_swallow dut (
    .clk(clk), .rst_n(rst_n), .pre_pulse_i(pre_pulse_i), .cfg_wr_i(cfg_wr_i),
    .cfg_n_i(cfg_n_i), .cfg_a_i(cfg_a_i), .cfg_sel_i(cfg_sel_i),
    .mod_ctl_o(mod_ctl_o), .mod_sel_o(mod_sel_o), .cmp_o(cmp_o), .cfg_err_o(cfg_err_o)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  int m_n, m_a, m_act_n, m_act_a, m_act_sel;
  int m_sh_n, m_sh_a, m_sh_sel, m_pend, m_err, m_cmp;

  // stimulus control
  bit wr_req = 0, wr_at_reload = 0, stall = 0;
  int wr_n, wr_a, wr_sel;
  int rem = 0;
  int cyc = 0, last_cmp = -1, exp_period = 0, cmp_cnt = 0;
  bit period_ok = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 3; m_a = 0; m_act_n = 3; m_act_a = 0; m_act_sel = 0;
      m_sh_n = 3; m_sh_a = 0; m_sh_sel = 0; m_pend = 0; m_err = 0; m_cmp = 0;
    end else begin
      bit term;
      term  = pre_pulse_i && (m_n == 1);
      m_cmp = term;
      if (term) begin
        if (m_pend != 0) begin
          m_act_n = m_sh_n; m_act_a = m_sh_a; m_act_sel = m_sh_sel; m_pend = 0;
        end
        m_n = m_act_n; m_a = m_act_a;
      end else if (pre_pulse_i) begin
        m_n--;
        if (m_a > 0) m_a--;
      end
      if (cfg_wr_i) begin
        int cn, ca;
        cn = (cfg_n_i < 3) ? 3 : int'(cfg_n_i);            // R7
        ca = (int'(cfg_a_i) >= cn) ? cn - 1 : int'(cfg_a_i); // R8
        m_sh_n = cn; m_sh_a = ca; m_sh_sel = cfg_sel_i; m_pend = 1;
        m_err  = (cfg_n_i < 3) || (int'(cfg_a_i) >= int'(cfg_n_i));
      end
    end
  end

  // compare, then drive: all away from the rising edge
  initial begin
    pre_pulse_i = 0; cfg_wr_i = 0; cfg_n_i = 0; cfg_a_i = 0; cfg_sel_i = 0;
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        cyc++;
        chk(mod_ctl_o == (m_a != 0), "R2/R9 mod_ctl", mod_ctl_o, int'(m_a != 0));
        chk(cmp_o == m_cmp[0], "R3/R5 cmp", cmp_o, m_cmp);
        chk(mod_sel_o == m_act_sel[0], "R5/R6 mod_sel", mod_sel_o, m_act_sel);
        chk(cfg_err_o == m_err[0], "R7/R8 cfg_err", cfg_err_o, m_err);
        if (cmp_o) begin
          cmp_cnt++;
          if (last_cmp >= 0 && period_ok)
            chk(cyc - last_cmp == exp_period, "R4 period", cyc - last_cmp, exp_period);
          exp_period = (m_act_sel ? P_HI : P_LO) * m_act_n + m_act_a;
          last_cmp   = cyc;
          period_ok  = 1;
        end
        // prescaler model
        if (stall) begin
          pre_pulse_i = 0;
          period_ok   = 0;
        end else begin
          if (rem == 0) rem = mod_ctl_o ? (mod_sel_o ? P_HI : P_LO) + 1 : (mod_sel_o ? P_HI : P_LO);
          rem--;
          pre_pulse_i = (rem == 0);
        end
        // configuration writes
        if (wr_req && (!wr_at_reload || (pre_pulse_i && m_n == 1))) begin
          cfg_wr_i = 1; cfg_n_i = 11'(wr_n); cfg_a_i = 7'(wr_a); cfg_sel_i = wr_sel[0];
          wr_req = 0;
        end else begin
          cfg_wr_i = 0;
        end
      end
    end
  end

  task automatic wait_cmps(input int k);
    int target;
    target = cmp_cnt + k;
    while (cmp_cnt < target) @(negedge clk);
  endtask

  task automatic write_cfg(input int n, input int a, input int sel, input bit at_reload);
    wr_n = n; wr_a = a; wr_sel = sel; wr_at_reload = at_reload; wr_req = 1;
    while (wr_req) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R3 actual=no_finish expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmp_o == 0, "R1 cmp", cmp_o, 0);
    chk(mod_ctl_o == 0, "R1 mod_ctl", mod_ctl_o, 0);
    chk(mod_sel_o == 0, "R1 mod_sel", mod_sel_o, 0);
    chk(cfg_err_o == 0, "R1 cfg_err", cfg_err_o, 0);
    rst_n = 1;
    wait_cmps(3);                 // default N=3, A=0 (R2 A=0 case)
    write_cfg(5, 2, 0, 0);        // R5 deferred to next reload
    wait_cmps(4);
    write_cfg(10, 9, 1, 0);       // R6 select change, A=N-1
    wait_cmps(3);
    write_cfg(1, 0, 0, 0);        // R7 N below floor
    wait_cmps(3);
    write_cfg(6, 8, 1, 0);        // R8 A not below N
    wait_cmps(2);
    stall = 1;                    // R9 strobes absent
    repeat (40) @(negedge clk);
    stall = 0;
    wait_cmps(3);
    write_cfg(4, 3, 0, 1);        // R5 write in the reload clock
    wait_cmps(3);
    write_cfg(130, 127, 1, 0);    // wide A
    wait_cmps(3);
    write_cfg(7, 1, 0, 0);        // R5 overwrite before reload
    write_cfg(3, 2, 1, 0);
    wait_cmps(3);
    write_cfg(2, 2, 0, 1);        // R7/R8 both illegal, at reload
    wait_cmps(3);
    finish_run();
  end

endmodule